// File: doc/BRIEF.md
# Self-Advancing Fall-Through FIFO with Strobe Handshakes

This block is a first-in first-out buffer of 64 words, each 4 bits wide, built as a chain of stages rather than as a RAM with read and write pointers. Every stage holds one word and an occupancy flag. A word accepted at the head stage moves toward the tail stage by itself, one position per clock, whenever the stage ahead of it is empty. Words therefore pile up at the tail, and empty slots drift back toward the head.

The write side uses a level strobe `shiftIn` and the flag `inReady`. The read side uses a level strobe `shiftOut` and the flag `outReady`. Both strobes are sampled on the single clock, and their rising edges are detected. A held strobe also holds the stage it concerns: the head keeps a word while `shiftIn` stays high, and the tail keeps its word and refuses a refill while `shiftOut` stays high. An active-low reset empties the whole chain.

Top module: `bubble_fifo`

## Requirements
- R1: The buffer accepts exactly 64 words. After 63 accepted writes, once the chain has settled, `inReady` is high. After the 64th, `inReady` stays low.
- R2: `inReady` is high exactly when the head stage is empty. While the chain is not full, an empty head is the state once it has settled.
- R3: A rising edge of `shiftIn` sampled while `inReady` is high stores `dataIn` in the head stage. `inReady` is low after that clock edge.
- R4: The stored word stays in the head stage for as long as `shiftIn` stays high, and `inReady` stays low during that time. On the first clock edge that samples `shiftIn` low, the word leaves the head, and `inReady` is high again after that edge if the next stage was empty.
- R5: A stage passes its word forward by at most one position per clock and never overtakes. A word written into an empty buffer raises `outReady` exactly 63 clock edges after the last edge that samples `shiftIn` high. Words leave in the order they were written.
- R6: `outReady` is high exactly when the tail stage holds a word, and `dataOut` shows that word. A rising edge of `shiftOut` while `outReady` is high consumes the word, so `outReady` is low after that edge. `dataOut` does not change while `shiftOut` stays high.
- R7: On the first clock edge that samples `shiftOut` low, a word waiting in the stage before the tail moves into the tail. `outReady` is high after that edge.
- R8: When the buffer has run empty, `outReady` stays low and `dataOut` keeps the last word it showed.
- R9: A `shiftIn` rising edge while `inReady` is low is ignored: no word is added and the stored words are unchanged.
- R10: A `shiftOut` rising edge while `outReady` is low has no effect. A word that arrives later is still delivered and can be read.
- R11: While `rstN` is low, every stage is emptied: `inReady` is 1 and `outReady` is 0. No stored word appears after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, empties all stages |
| shiftIn | input | 1 | Write strobe, level; the rising edge writes |
| dataIn | input | 4 | Word to be written |
| inReady | output | 1 | Head stage empty, a write will be accepted |
| shiftOut | input | 1 | Read strobe, level; the rising edge consumes |
| dataOut | output | 4 | Word in the tail stage; kept when empty |
| outReady | output | 1 | Tail stage holds a valid word |

## Verification
A corrupted occupancy flag in the middle of the chain shows up late. A word appears at the tail early, late, twice, or never. The exact 63-edge arrival count from an empty buffer exposes a stage that skips or stalls within one run through the chain. A broken head or tail hold shows within a single clock: `inReady` rises while `shiftIn` is still high, or `dataOut` changes while `shiftOut` is high. Capacity and ordering faults only show after a full fill and drain, where a word is missing or out of order, or a 65th word is taken.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;

  // Strobes from the handshake control to the stage chain.
  typedef struct packed {
    logic capture;   // store dataIn into the head stage this edge
    logic headHold;  // head stage may not pass its word on
    logic tailHold;  // tail stage may not be refilled
    logic consume;   // tail word taken by the reader this edge
  } chainCtl_t;

endpackage

// File: rtl/bubble_fifo_ctrl.sv
module bubble_fifo_ctrl
  import bubble_fifo_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      shiftIn,
  input  logic      shiftOut,
  input  logic      headFull,
  input  logic      tailFull,
  output chainCtl_t ctl,
  output logic      inReady,
  output logic      outReady
);

  logic inPrev;
  logic outPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPrev  <= 1'b0;
      outPrev <= 1'b0;
    end else begin
      inPrev  <= shiftIn;
      outPrev <= shiftOut;
    end
  end

  // Edges qualify only against the flag the other side sees.
  always_comb begin
    ctl.capture  = shiftIn & ~inPrev & ~headFull;
    ctl.headHold = shiftIn;
    ctl.tailHold = shiftOut;
    ctl.consume  = shiftOut & ~outPrev & tailFull;
  end

  assign inReady  = ~headFull;
  assign outReady = tailFull;

  // A consumed word may not be replaced in the same edge (refill is gated).
  assert_read_drops_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.consume |=> !outReady);

  // A capture always lowers the write-side flag.
  assert_capture_lowers_R3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> !inReady);

endmodule

// File: rtl/bubble_fifo_chain.sv
module bubble_fifo_chain
  import bubble_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  chainCtl_t        ctl,
  input  logic [WIDTH-1:0] dataIn,
  output logic             headFull,
  output logic             tailFull,
  output logic [WIDTH-1:0] dataOut
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] valid;
  logic [DEPTH-1:0] nextValid;
  logic [WIDTH-1:0] word     [DEPTH];
  logic [WIDTH-1:0] nextWord [DEPTH];
  logic [LAST-1:0]  advance;

  // Stage i hands its word to stage i+1 when the latter is empty.
  // The head is held by a high shiftIn, the tail refill by a high shiftOut.
  for (genvar i = 0; i < LAST; i++) begin : g_adv
    if (i == 0 && i == LAST - 1) begin : g_both
      assign advance[i] = valid[i] & ~valid[i+1] & ~ctl.headHold & ~ctl.tailHold;
    end else if (i == 0) begin : g_head
      assign advance[i] = valid[i] & ~valid[i+1] & ~ctl.headHold;
    end else if (i == LAST - 1) begin : g_tail
      assign advance[i] = valid[i] & ~valid[i+1] & ~ctl.tailHold;
    end else begin : g_mid
      assign advance[i] = valid[i] & ~valid[i+1];
    end
  end

  always_comb begin
    nextValid = valid;
    for (int i = 0; i < DEPTH; i++) nextWord[i] = word[i];
    if (ctl.capture) begin
      nextValid[0] = 1'b1;
      nextWord[0]  = dataIn;
    end
    for (int i = 0; i < LAST; i++) begin
      if (advance[i]) begin
        nextValid[i]   = 1'b0;
        nextValid[i+1] = 1'b1;
        nextWord[i+1]  = word[i];
      end
    end
    if (ctl.consume) nextValid[LAST] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valid <= '0;
      for (int i = 0; i < DEPTH; i++) word[i] <= '0;
    end else begin
      valid <= nextValid;
      for (int i = 0; i < DEPTH; i++) word[i] <= nextWord[i];
    end
  end

  assign headFull = valid[0];
  assign tailFull = valid[LAST];
  assign dataOut  = word[LAST];

  // The head keeps its word while the writer holds the strobe.
  assert_head_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (valid[0] && ctl.headHold) |=> (valid[0] && $stable(word[0])));

  // The tail word is frozen while the reader holds the strobe.
  assert_tail_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (valid[LAST] && ctl.tailHold) |=> $stable(word[LAST]));

  // Nothing upstream of an empty tail: the output keeps its last value.
  assert_empty_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!valid[LAST] && !valid[LAST-1]) |=> $stable(word[LAST]));

  // A stage only fills from its direct upstream neighbour (one step per clock).
  for (genvar i = 0; i < LAST; i++) begin : g_chk
    assert_one_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(valid[i+1]) |-> $past(valid[i]));
  end

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo
  import bubble_fifo_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             shiftIn,
  input  logic [WIDTH-1:0] dataIn,
  output logic             inReady,
  input  logic             shiftOut,
  output logic [WIDTH-1:0] dataOut,
  output logic             outReady
);

  chainCtl_t ctl;
  logic      headFull;
  logic      tailFull;

  bubble_fifo_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .shiftIn  (shiftIn),
    .shiftOut (shiftOut),
    .headFull (headFull),
    .tailFull (tailFull),
    .ctl      (ctl),
    .inReady  (inReady),
    .outReady (outReady)
  );

  bubble_fifo_chain #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_chain (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .dataIn   (dataIn),
    .headFull (headFull),
    .tailFull (tailFull),
    .dataOut  (dataOut)
  );

endmodule

// File: tb/sim_bubble_fifo.sv
module sim_bubble_fifo;

  localparam int DEPTH = 64;
  localparam int WIDTH = 4;
  localparam int NVEC  = 12;

  // bit 4: 1 = read (bits 3:0 expected), 0 = write (bits 3:0 written)
  localparam logic [4:0] VEC [NVEC] = '{
    5'h03, 5'h09, 5'h0C, 5'h13, 5'h00, 5'h19,
    5'h0F, 5'h1C, 5'h10, 5'h1F, 5'h06, 5'h16
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             shiftIn = 1'b0;
  logic             shiftOut = 1'b0;
  logic [WIDTH-1:0] dataIn = '0;
  logic             inReady;
  logic             outReady;
  logic [WIDTH-1:0] dataOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  bubble_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .shiftIn(shiftIn), .dataIn(dataIn),
    .inReady(inReady), .shiftOut(shiftOut), .dataOut(dataOut),
    .outReady(outReady)
  );

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic waitFlag(input bit wantIn, input string req);
    int n = 0;
    while ((wantIn ? inReady : outReady) !== 1'b1 && n < 500) begin
      tick();
      n++;
    end
    if (n >= 500) chk(req, 0, 1);
  endtask

  task automatic writeWord(input logic [WIDTH-1:0] v);
    waitFlag(1'b1, "R2 ready for write");
    dataIn  = v;
    shiftIn = 1'b1;
    tick();
    shiftIn = 1'b0;
    tick();
  endtask

  task automatic readWord(input logic [WIDTH-1:0] exp, input string req);
    waitFlag(1'b0, req);
    chk(req, int'(dataOut), int'(exp));
    shiftOut = 1'b1;
    tick();
    chk("R6 outReady low after read edge", int'(outReady), 0);
    shiftOut = 1'b0;
    tick();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    shiftIn = 1'b0;
    shiftOut = 1'b0;
    tick();
    tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int cnt;
    @(negedge clk);
    tick();
    // R11 / R2: reset state
    chk("R11 inReady in reset", int'(inReady), 1);
    chk("R11 outReady in reset", int'(outReady), 0);
    rstN = 1'b1;
    tick();

    // Vector table: writes and ordered reads (R5)
    for (int k = 0; k < NVEC; k++) begin
      if (VEC[k][4]) readWord(VEC[k][3:0], "R5 table read order");
      else           writeWord(VEC[k][3:0]);
    end

    // R5 latency and R3/R4 flag behaviour, one-cycle write pulse
    repeat (10) tick();
    dataIn = 4'h5;
    shiftIn = 1'b1;
    tick();
    chk("R3 inReady low after capture", int'(inReady), 0);
    shiftIn = 1'b0;
    cnt = 0;
    while (!outReady && cnt < 300) begin
      tick();
      cnt++;
      if (cnt == 1) chk("R4 inReady high after release", int'(inReady), 1);
    end
    chk("R5 latency single pulse", cnt, DEPTH - 1);
    readWord(4'h5, "R5 latency word value");

    // R4: hold shiftIn high for 5 edges
    dataIn = 4'hA;
    shiftIn = 1'b1;
    for (int h = 0; h < 5; h++) begin
      tick();
      chk("R4 inReady low while held", int'(inReady), 0);
    end
    dataIn = 4'h1;
    shiftIn = 1'b0;
    cnt = 0;
    while (!outReady && cnt < 300) begin
      tick();
      cnt++;
    end
    chk("R4 latency counted from release", cnt, DEPTH - 1);
    readWord(4'hA, "R4 held word value");

    // R6 / R7: output held while shiftOut is high
    writeWord(4'h7);
    writeWord(4'h2);
    waitFlag(1'b0, "R6 first word arrives");
    repeat (100) tick();
    chk("R6 dataOut shows word", int'(dataOut), 7);
    shiftOut = 1'b1;
    for (int h = 0; h < 6; h++) begin
      tick();
      chk("R6 outReady low while shiftOut high", int'(outReady), 0);
      chk("R6 dataOut stable while shiftOut high", int'(dataOut), 7);
    end
    shiftOut = 1'b0;
    tick();
    chk("R7 outReady after release", int'(outReady), 1);
    chk("R7 next word moved in", int'(dataOut), 2);
    readWord(4'h2, "R7 second word");

    // R8: empty keeps last data
    for (int h = 0; h < 100; h++) tick();
    chk("R8 outReady low when empty", int'(outReady), 0);
    chk("R8 dataOut keeps last", int'(dataOut), 2);

    // R10: read attempts with outReady low
    shiftOut = 1'b1; tick(); shiftOut = 1'b0; tick();
    chk("R10 dataOut unchanged by idle read", int'(dataOut), 2);
    writeWord(4'hD);
    repeat (10) tick();
    shiftOut = 1'b1; tick(); shiftOut = 1'b0; tick();
    readWord(4'hD, "R10 word survives early read");

    // R1 / R9: capacity and ignored write when full
    doReset();
    for (int k = 0; k < DEPTH - 1; k++) writeWord(4'(k) ^ 4'h5);
    repeat (200) tick();
    chk("R1 inReady high with 63 stored", int'(inReady), 1);
    writeWord(4'(DEPTH - 1) ^ 4'h5);
    repeat (200) tick();
    chk("R1 inReady low when full", int'(inReady), 0);
    dataIn = 4'hE;
    shiftIn = 1'b1; tick(); shiftIn = 1'b0; tick();
    chk("R9 inReady still low", int'(inReady), 0);
    for (int k = 0; k < DEPTH; k++) readWord(4'(k) ^ 4'h5, "R1 drain order");
    repeat (150) tick();
    chk("R9 no extra word after drain", int'(outReady), 0);
    chk("R2 inReady high when empty", int'(inReady), 1);

    // R11: reset mid-operation
    writeWord(4'h3);
    writeWord(4'h4);
    writeWord(4'h8);
    repeat (30) tick();
    rstN = 1'b0;
    tick();
    chk("R11 inReady after reset", int'(inReady), 1);
    chk("R11 outReady after reset", int'(outReady), 0);
    rstN = 1'b1;
    repeat (120) tick();
    chk("R11 nothing emerges after reset", int'(outReady), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule